// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This unit performs the data operations of an 8-bit accumulator processor: binary add and subtract with carry, compare, the three bitwise logic operations, the bit test, shifts and rotates through the carry, and increment and decrement. Each request carries an operation code, the register operand (accumulator or index), the memory operand and the present carry. The unit returns the 8-bit result, a result write enable, and new values for the N, V, Z and C flags, each with its own write enable. Flags whose enable is low must be kept by the caller. Decimal mode does not exist here: all arithmetic is binary.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel. There is one output register. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` high from the following cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds every bit of its result and no new request is accepted. With `out_ready` held high, one request per cycle flows through.

Top module: `byte_alu`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted request produces `out_valid` on the next cycle. While stalled, the output holds every bit and `out_valid` stays high. A result leaves on the edge where `out_ready` is high, and `out_valid` drops if no request was accepted on that edge.
- R2: Op 0 (add) returns (A+M+C) mod 256. C is set when the sum exceeds 255. V is set when A and M have the same sign bit and the result's sign differs from A. N is result bit 7 and Z is set when the result is zero. All four flag enables and the result enable are high.
- R3: Op 1 (subtract) returns (A−M−(1−C)) mod 256. C is 1 when the true difference is not negative. V is set when A and M differ in sign and the result's sign differs from A. N and Z come from the result. All four flag enables and the result enable are high.
- R4: Op 2 (compare) places (A−M) mod 256 on `out_res` with the result enable low. C is set when A ≥ M unsigned. N and Z come from the difference. V is not written.
- R5: Ops 3, 4 and 5 (AND, OR, XOR of A and M) write the result and enable only N and Z.
- R6: Op 6 (bit test) sets N from M bit 7 and V from M bit 6. Z is set when A AND M is zero. The result enable and the C enable are low.
- R7: Op 7 (shift left) moves bit 7 into C and brings in 0. Op 8 (shift right) moves bit 0 into C, brings in 0 and writes N as 0. Both enable N, Z and C.
- R8: Op 9 (rotate left) brings the incoming C into bit 0 and moves bit 7 into C. Op 10 (rotate right) brings the incoming C into bit 7 and moves bit 0 into C. Both enable N, Z and C.
- R9: Ops 11 and 12 add or subtract one from A modulo 256, write the result, and enable only N and Z.
- R10: Ops 13 to 15 are undefined. They give result 0 with the result enable and all flag enables low.
- R11: A flag whose enable is low reads as 0 in `out_flag_val`. After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code 0..15 |
| in_a | input | 8 | Register operand (A, X or Y) |
| in_m | input | 8 | Memory operand |
| in_c | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 8 | Result byte |
| out_res_we | output | 1 | Result should be written back |
| out_flag_val | output | 4 | New flags {N, V, Z, C} |
| out_flag_we | output | 4 | Flag write enables {N, V, Z, C} |

## Verification
The hardest conditions to reach from the ports are the sign boundaries of the arithmetic. These are signed overflow at 0x7F/0x80, a borrow produced only by an incoming carry of 0, and a compare of equal operands. Uniform random operands seldom land on them, so directed requests target each one before the random phase. A second hard condition is a held result while the consumer stalls. To reach it, the bench holds `out_ready` low for a random number of cycles after each result appears. During the stall it checks that the output does not move and that `in_ready` stays low. A back-to-back pair with `out_ready` held high covers the full-rate path.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CMP = 4'd2, OP_AND = 4'd3,
    OP_OR  = 4'd4, OP_XOR = 4'd5, OP_BIT = 4'd6, OP_SHL = 4'd7,
    OP_SHR = 4'd8, OP_ROL = 4'd9, OP_ROR = 4'd10, OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {SH_LEFT, SH_RIGHT, RO_LEFT, RO_RIGHT} shift_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logic_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_V = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;
endpackage

// File: rtl/byte_alu_adder.sv
module byte_alu_adder #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b_raw,
  input  logic          invert_b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  localparam int MSB = DW - 1;
  logic [DW-1:0] b_eff;
  logic [DW:0]   full;

  always_comb begin
    b_eff = invert_b ? ~b_raw : b_raw;
    full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    sum   = full[DW-1:0];
    cout  = full[DW];
    ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
  end
endmodule

// File: rtl/byte_alu_shifter.sv
module byte_alu_shifter
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  shift_e        mode,
  output logic [DW-1:0] res,
  output logic          cout
);
  always_comb begin
    unique case (mode)
      SH_LEFT:  {cout, res} = {a, 1'b0};
      SH_RIGHT: {res, cout} = {1'b0, a};
      RO_LEFT:  {cout, res} = {a, cin};
      default:  {res, cout} = {cin, a};
    endcase
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic_e        mode,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (mode)
      LG_OR:   res = a | m;
      LG_XOR:  res = a ^ m;
      default: res = a & m;
    endcase
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_m,
  input  logic          in_c,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_res,
  output logic          out_res_we,
  output logic [3:0]    out_flag_val,
  output logic [3:0]    out_flag_we
);
  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  alu_op_e       op;
  logic [DW-1:0] add_sum, sh_res, lg_res, nxt_res;
  logic          add_co, add_v, sh_co, nxt_we, nxt_zero;
  logic [3:0]    nxt_fv, nxt_fwe;
  shift_e        sh_mode;
  logic_e        lg_mode;
  logic          accept;

  assign op = alu_op_e'(in_op);

  byte_alu_adder #(.DW(DW)) u_adder (
    .a(in_a), .b_raw(in_m), .invert_b(op != OP_ADD),
    .cin((op == OP_CMP) ? 1'b1 : in_c),
    .sum(add_sum), .cout(add_co), .ovf(add_v)
  );

  always_comb begin
    unique case (op)
      OP_SHR:  sh_mode = SH_RIGHT;
      OP_ROL:  sh_mode = RO_LEFT;
      OP_ROR:  sh_mode = RO_RIGHT;
      default: sh_mode = SH_LEFT;
    endcase
    unique case (op)
      OP_OR:   lg_mode = LG_OR;
      OP_XOR:  lg_mode = LG_XOR;
      default: lg_mode = LG_AND;
    endcase
  end

  byte_alu_shifter #(.DW(DW)) u_shift (
    .a(in_a), .cin(in_c), .mode(sh_mode), .res(sh_res), .cout(sh_co)
  );

  byte_alu_logic #(.DW(DW)) u_logic (
    .a(in_a), .m(in_m), .mode(lg_mode), .res(lg_res)
  );

  always_comb begin
    nxt_res = '0;
    nxt_we  = 1'b0;
    nxt_fv  = 4'b0000;
    nxt_fwe = 4'b0000;
    unique case (op)
      OP_ADD, OP_SUB: begin nxt_res = add_sum; nxt_we = 1'b1; nxt_fwe = 4'b1111; end
      OP_CMP:         begin nxt_res = add_sum; nxt_fwe = 4'b1011; end
      OP_AND, OP_OR, OP_XOR: begin nxt_res = lg_res; nxt_we = 1'b1; nxt_fwe = 4'b1010; end
      OP_BIT:         begin nxt_res = lg_res; nxt_fwe = 4'b1110; end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin nxt_res = sh_res; nxt_we = 1'b1; nxt_fwe = 4'b1011; end
      OP_INC:         begin nxt_res = in_a + ONE; nxt_we = 1'b1; nxt_fwe = 4'b1010; end
      OP_DEC:         begin nxt_res = in_a - ONE; nxt_we = 1'b1; nxt_fwe = 4'b1010; end
      default: ;
    endcase
    nxt_zero = (nxt_res == '0);
    nxt_fv[FLAG_N] = nxt_fwe[FLAG_N] & nxt_res[MSB];
    nxt_fv[FLAG_Z] = nxt_fwe[FLAG_Z] & nxt_zero;
    if (op == OP_BIT) begin
      nxt_fv[FLAG_N] = in_m[MSB];
      nxt_fv[FLAG_V] = in_m[MSB-1];
    end else if (op == OP_ADD || op == OP_SUB) begin
      nxt_fv[FLAG_V] = add_v;
    end
    if (op == OP_ADD || op == OP_SUB || op == OP_CMP) nxt_fv[FLAG_C] = add_co;
    else if (nxt_fwe[FLAG_C])                          nxt_fv[FLAG_C] = sh_co;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_res      <= '0;
      out_res_we   <= 1'b0;
      out_flag_val <= 4'b0000;
      out_flag_we  <= 4'b0000;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_res      <= nxt_res;
      out_res_we   <= nxt_we;
      out_flag_val <= nxt_fv;
      out_flag_we  <= nxt_fwe;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_flag_val) && $stable(out_flag_we)); // R1
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R1
  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_res_we |-> out_flag_val[FLAG_Z] == (out_res == '0)); // R2
  AST_CMP_BIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == 4'd2 || in_op == 4'd6) |=> !out_res_we); // R4
  AST_SHR_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 4'd8 |=> out_flag_we[FLAG_N] && !out_flag_val[FLAG_N]); // R7
  AST_INCDEC_NZ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == 4'd11 || in_op == 4'd12) |=> out_flag_we == 4'b1010); // R9
  AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op >= 4'd13 |=> out_flag_we == 4'b0000 && !out_res_we); // R10
  AST_OFF_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flag_val & ~out_flag_we) == 4'b0000); // R11
endmodule

// File: tb/tb_byte_alu.sv
`timescale 1ns/1ps
module tb_byte_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_c = 1'b0;
  logic [3:0] in_op = 4'd0;
  logic [7:0] in_a = 8'd0, in_m = 8'd0;
  logic out_valid, out_ready = 1'b0, out_res_we;
  logic [7:0] out_res;
  logic [3:0] out_flag_val, out_flag_we;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  byte_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_m(in_m), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_res_we(out_res_we), .out_flag_val(out_flag_val), .out_flag_we(out_flag_we)
  );

  // {res_we, res[7:0], flags {N,V,Z,C}, enables {N,V,Z,C}}
  function automatic logic [16:0] model(int op, logic [7:0] a, logic [7:0] m, logic c);
    logic [7:0] r; logic we; logic n, v, z, cy; logic [3:0] en; int s;
    r = 8'd0; we = 1'b0; v = 1'b0; cy = 1'b0; en = 4'b0000;
    case (op)
      0: begin s = int'(a) + int'(m) + int'(c); r = s[7:0]; cy = s > 255;
               v = (a[7] == m[7]) && (r[7] != a[7]); we = 1; en = 4'b1111; end
      1: begin s = int'(a) - int'(m) - (c ? 0 : 1); r = s[7:0]; cy = s >= 0;
               v = (a[7] != m[7]) && (r[7] != a[7]); we = 1; en = 4'b1111; end
      2: begin s = int'(a) - int'(m); r = s[7:0]; cy = a >= m; en = 4'b1011; end
      3: begin r = a & m; we = 1; en = 4'b1010; end
      4: begin r = a | m; we = 1; en = 4'b1010; end
      5: begin r = a ^ m; we = 1; en = 4'b1010; end
      6: begin r = a & m; v = m[6]; en = 4'b1110; end
      7: begin r = {a[6:0], 1'b0}; cy = a[7]; we = 1; en = 4'b1011; end
      8: begin r = {1'b0, a[7:1]}; cy = a[0]; we = 1; en = 4'b1011; end
      9: begin r = {a[6:0], c}; cy = a[7]; we = 1; en = 4'b1011; end
      10: begin r = {c, a[7:1]}; cy = a[0]; we = 1; en = 4'b1011; end
      11: begin r = a + 8'd1; we = 1; en = 4'b1010; end
      12: begin r = a - 8'd1; we = 1; en = 4'b1010; end
      default: ;
    endcase
    n = (op == 6) ? m[7] : r[7];
    z = (r == 8'd0);
    return {we, r, n & en[3], v & en[2], z & en[1], cy & en[0], en};
  endfunction

  function automatic string tag(int op);
    case (op)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3, 4, 5: return "R5"; 6: return "R6"; 7, 8: return "R7";
      9, 10: return "R8"; 11, 12: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic logic [16:0] got();
    return {out_res_we, out_res, out_flag_val, out_flag_we};
  endfunction

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(int op, logic [7:0] a, logic [7:0] m, logic c, int stall);
    logic [16:0] snap;
    @(negedge clk);
    in_op = 4'(op); in_a = a; in_m = m; in_c = c; in_valid = 1'b1;
    check("R1", {16'd0, in_ready}, 17'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {16'd0, out_valid}, 17'd1);
    snap = got();
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check("R1", {out_valid, in_ready, got()[14:0]}, {2'b10, snap[14:0]});
      check("R1", {16'd0, out_res_we}, {16'd0, snap[16]});
    end
    check(tag(op), got(), model(op, a, m, c));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R1", {16'd0, out_valid}, 17'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11", {15'd0, out_valid, in_ready}, 17'b01);
    rst_n = 1'b1;
    // directed corners
    run(0, 8'h7F, 8'h01, 1'b0, 1);  // R2 signed overflow
    run(0, 8'hFF, 8'h00, 1'b1, 0);  // R2 carry out, zero
    run(0, 8'h80, 8'h80, 1'b0, 0);  // R2 negative overflow
    run(1, 8'h80, 8'h01, 1'b1, 2);  // R3 overflow
    run(1, 8'h00, 8'h00, 1'b0, 0);  // R3 borrow from carry only
    run(1, 8'h05, 8'h05, 1'b1, 0);  // R3 zero, no borrow
    run(2, 8'h42, 8'h42, 1'b0, 0);  // R4 equal
    run(2, 8'h10, 8'h20, 1'b1, 0);  // R4 less
    run(6, 8'h00, 8'hC0, 1'b1, 0);  // R6 N,V from M, Z set
    run(6, 8'hFF, 8'h01, 1'b0, 0);  // R6
    run(8, 8'hFF, 8'h00, 1'b0, 0);  // R7 N cleared
    run(7, 8'h80, 8'h00, 1'b1, 0);  // R7 zero with carry
    run(9, 8'h80, 8'h00, 1'b1, 0);  // R8
    run(10, 8'h01, 8'h00, 1'b1, 0); // R8
    run(11, 8'hFF, 8'h00, 1'b1, 0); // R9 wrap
    run(12, 8'h00, 8'h00, 1'b0, 0); // R9 wrap
    run(3, 8'hF0, 8'h0F, 1'b1, 0);  // R5 zero
    run(13, 8'h12, 8'h34, 1'b1, 1); // R10
    run(15, 8'hFF, 8'hFF, 1'b1, 0); // R10
    // R1 full rate, two back-to-back requests
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_op = 4'd0; in_a = 8'h10; in_m = 8'h20; in_c = 1'b0;
    @(negedge clk);
    check("R1", got(), model(0, 8'h10, 8'h20, 1'b0));
    check("R1", {16'd0, in_ready}, 17'd1);
    in_op = 4'd1; in_a = 8'h30; in_m = 8'h31; in_c = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", got(), model(1, 8'h30, 8'h31, 1'b1));
    @(negedge clk);
    out_ready = 1'b0;
    check("R1", {16'd0, out_valid}, 17'd0);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      run(int'($urandom_range(15, 0)), 8'($urandom), 8'($urandom),
          1'($urandom), int'($urandom_range(2, 0)));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule